// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Data Memory

This block is a synchronous data store for a processor pipeline. It is addressed in bytes over a 32-bit address and holds 32-bit words, each made of four consecutive bytes, so the word with number n starts at byte address 4n. One access is issued each clock. It is either a full word at a word-aligned address or a single byte at any address. A registered result is returned on the following clock. A byte load places the chosen byte in the low eight bits of the result and fills the upper bits with zeros.

A run-time order input chooses how the byte offset inside a word maps to a bit lane. With little-endian numbering, offset 0 is the least significant byte. With big-endian numbering, offset 0 is the most significant byte. Word addresses and whole-word contents do not change with the order setting; only byte accesses move between lanes.

A word access whose address is not a multiple of four sets a flag that is returned with its result, and any store it carries is dropped. The number of stored words is a parameter. Address bits above the index field are ignored, so addresses that differ only in those bits reach the same word.

Top module: `endian_dmem`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `rd_data` is 0 and `misalign` is 0.
- R2: A word store (`size_sel`=1, `wr_en`=1) at an address with bits [1:0]=0 writes all 32 bits. A word load from that address returns the value on `rd_data` one clock after the address is presented.
- R3: A word written with one `big_end` setting reads back unchanged with the other setting.
- R4: With `big_end`=0, byte offset k (address bits [1:0]) maps to word bits [8k+7:8k].
- R5: With `big_end`=1, byte offset k maps to word bits [31-8k:24-8k].
- R6: A byte load (`size_sel`=0) returns the selected byte in `rd_data[7:0]`, with `rd_data[31:8]` equal to 0.
- R7: A byte store writes `wdata[7:0]` into its one lane only. The other three bytes of the word keep their values, and `wdata[31:8]` is ignored.
- R8: A word access with address bits [1:0] nonzero sets `misalign` on the next clock and changes no stored byte. In that case `rd_data` carries the word at the address with its low two bits cleared. Aligned accesses return `misalign`=0.
- R9: A byte access never sets `misalign`, at any of the four offsets.
- R10: Only address bits [log2(DEPTH)+1:2] select the word. Addresses that differ only in higher bits access the same word.
- R11: When a load and a store reach the same word on the same clock, the load returns the contents from before the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset of the result registers |
| addr | input | 32 | Byte address of the access |
| wdata | input | 32 | Store data; only bits [7:0] are used for a byte store |
| wr_en | input | 1 | 1 = store, 0 = load only |
| size_sel | input | 1 | 1 = word access, 0 = byte access |
| big_end | input | 1 | 1 = big-endian byte numbering, 0 = little-endian |
| rd_data | output | 32 | Registered load result, one clock after the address |
| misalign | output | 1 | Registered flag: the word access on the previous clock was not aligned |

## Verification
The bench reads all four offsets of one known word in both orders. A design with the lane formula reversed, or one that ignored `big_end`, would return bytes in mirrored positions. It stores single bytes at interior offsets under each order and then reads the whole word. Writing all four lanes, or writing the lane for the wrong order, would corrupt neighbouring bytes. It issues misaligned word stores and loads, then reloads the word. A missing write gate would change memory, and a misaligned check applied to byte accesses would raise the flag at offsets 1 to 3. Aliased high addresses and a store and load to the same word on one clock expose decoding of too many index bits and a write-first read port.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } byte_order_e;
endpackage

// File: rtl/dmem_lane_map.sv
// Converts a byte offset inside a word into a physical lane for the chosen order.
module dmem_lane_map #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]      offset,
    input  dmem_pkg::byte_order_e order,
    output logic [OFF_W-1:0]      lane_idx,
    output logic [LANES-1:0]      lane_oh
);
    always_comb begin
        unique case (order)
            dmem_pkg::ORD_BIG:    lane_idx = OFF_W'(LANES - 1) - offset;
            dmem_pkg::ORD_LITTLE: lane_idx = offset;
            default:              lane_idx = offset;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_oh
        assign lane_oh[g] = (lane_idx == OFF_W'(g));
    end
endmodule

// File: rtl/dmem_store_ctl.sv
// Produces per-lane write enables and lane data; drops misaligned word stores.
module dmem_store_ctl #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic                  wr_en,
    input  dmem_pkg::acc_size_e   size,
    input  logic [OFF_W-1:0]      offset,
    input  logic [LANES-1:0]      lane_oh,
    input  logic [WORD_W-1:0]     wdata,
    output logic                  misaligned,
    output logic [LANES-1:0]      lane_we,
    output logic [WORD_W-1:0]     lane_wdata
);
    always_comb begin
        misaligned = 1'b0;
        lane_we    = '0;
        unique case (size)
            dmem_pkg::SZ_WORD: begin
                misaligned = (offset != '0);
                lane_we    = (wr_en && (offset == '0)) ? '1 : '0;
            end
            dmem_pkg::SZ_BYTE: begin
                lane_we = wr_en ? lane_oh : '0;
            end
            default: begin
                lane_we = '0;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_wd
        assign lane_wdata[g*LANE_W +: LANE_W] =
            (size == dmem_pkg::SZ_WORD) ? wdata[g*LANE_W +: LANE_W] : wdata[LANE_W-1:0];
    end
endmodule

// File: rtl/dmem_word_array.sv
// One storage bank per lane with a registered, read-before-write port.
module dmem_word_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0] lane_wdata,
    output logic [WORD_W-1:0] rd_word
);
    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                bank[idx] <= lane_wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_word[g*LANE_W +: LANE_W] <= '0;
            end else begin
                rd_word[g*LANE_W +: LANE_W] <= bank[idx];
            end
        end
    end
endmodule

// File: rtl/dmem_read_sel.sv
// Picks the registered lane for byte loads, or passes the full word.
module dmem_read_sel #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0]   rd_word,
    input  dmem_pkg::acc_size_e size_q,
    input  logic [OFF_W-1:0]    lane_q,
    output logic [WORD_W-1:0]   rd_data
);
    logic [LANE_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_q == OFF_W'(i)) picked = rd_word[i*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        unique case (size_q)
            dmem_pkg::SZ_WORD: rd_data = rd_word;
            dmem_pkg::SZ_BYTE: rd_data = {{(WORD_W-LANE_W){1'b0}}, picked};
            default:           rd_data = rd_word;
        endcase
    end
endmodule

// File: rtl/endian_dmem.sv
module endian_dmem #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              size_sel,
    input  logic              big_end,
    output logic [WORD_W-1:0] rd_data,
    output logic              misalign
);
    import dmem_pkg::*;

    acc_size_e         size;
    byte_order_e       order;
    logic [OFF_W-1:0]  offset;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  lane_idx;
    logic [LANES-1:0]  lane_oh;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] rd_word;
    logic              misaligned;
    acc_size_e         size_q;
    logic [OFF_W-1:0]  lane_q;
    logic              unused_hi_addr;

    assign size           = acc_size_e'(size_sel);
    assign order          = byte_order_e'(big_end);
    assign offset         = addr[OFF_W-1:0];
    assign idx            = addr[OFF_W +: IDX_W];
    assign unused_hi_addr = ^addr[31:OFF_W+IDX_W];

    dmem_lane_map #(.LANES(LANES)) u_map (
        .offset   (offset),
        .order    (order),
        .lane_idx (lane_idx),
        .lane_oh  (lane_oh)
    );

    dmem_store_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_st (
        .wr_en      (wr_en),
        .size       (size),
        .offset     (offset),
        .lane_oh    (lane_oh),
        .wdata      (wdata),
        .misaligned (misaligned),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata)
    );

    dmem_word_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .lane_we    (lane_we),
        .lane_wdata (lane_wdata),
        .rd_word    (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= SZ_WORD;
            lane_q   <= '0;
            misalign <= 1'b0;
        end else begin
            size_q   <= size;
            lane_q   <= lane_idx;
            misalign <= misaligned;
        end
    end

    dmem_read_sel #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .rd_word (rd_word),
        .size_q  (size_q),
        .lane_q  (lane_q),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/dmem_chk.sv
module dmem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] addr,
    input logic        wr_en,
    input logic        size_sel,
    input logic        big_end,
    input logic [31:0] rd_data,
    input logic        misalign,
    input logic [3:0]  lane_we
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 32'h0 && !misalign)); // R1
    AST_MISALIGN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel && addr[1:0] != 2'b00) |=> misalign); // R8
    AST_MISALIGN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> $past(size_sel && addr[1:0] != 2'b00)); // R9
    AST_NO_MISALIGNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (size_sel && addr[1:0] != 2'b00) |-> lane_we == 4'b0000); // R8
    AST_ONE_LANE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_sel) |-> $countones(lane_we) == 1); // R7
    AST_LITTLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_sel && !big_end) |-> lane_we[addr[1:0]]); // R4
    AST_BIG_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !size_sel && big_end) |-> lane_we[2'd3 - addr[1:0]]); // R5
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !size_sel |=> rd_data[31:8] == 24'h0); // R6
endmodule

bind endian_dmem dmem_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .size_sel (size_sel),
    .big_end  (big_end),
    .rd_data  (rd_data),
    .misalign (misalign),
    .lane_we  (lane_we)
);

// File: tb/sim_endian_dmem.sv
`timescale 1ns/1ps
module sim_endian_dmem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        size_sel = 1'b0;
    logic        big_end = 1'b0;
    logic [31:0] rd_data;
    logic        misalign;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] q_data [$];
    logic        q_mis  [$];
    bit          q_chk  [$];
    string       q_tag  [$];

    always #2 clk = ~clk;

    endian_dmem u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .size_sel(size_sel), .big_end(big_end), .rd_data(rd_data), .misalign(misalign)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one access per clock and queues its expected result.
    task automatic drive(input logic [31:0] a, input logic [31:0] d, input bit we,
                         input bit word, input bit be, input bit chk,
                         input logic [31:0] ed, input bit em, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_en = we; size_sel = word; big_end = be;
        q_data.push_back(ed); q_mis.push_back(em); q_chk.push_back(chk); q_tag.push_back(tag);
    endtask

    // Monitor: the result of an access is visible just after the next rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_chk.size() > 0) begin
                automatic logic [31:0] ed = q_data.pop_front();
                automatic logic        em = q_mis.pop_front();
                automatic bit          c  = q_chk.pop_front();
                automatic string       t  = q_tag.pop_front();
                if (c) begin
                    check({t, " data"}, rd_data, ed);
                    check({t, " misalign"}, {31'b0, misalign}, {31'b0, em});
                end
            end
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data", rd_data, 32'h0);
        check("R1 reset misalign", {31'b0, misalign}, 32'h0);
        rst_n = 1'b1;
        // word store then loads in both orders
        drive(32'h10, 32'hA1B2C3D4, 1, 1, 0, 0, 32'h0, 0, "R2");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hA1B2C3D4, 0, "R2");
        drive(32'h10, 32'h0, 0, 1, 1, 1, 32'hA1B2C3D4, 0, "R3");
        // byte loads, little then big numbering
        drive(32'h10, 32'h0, 0, 0, 0, 1, 32'hD4, 0, "R4 R6 off0");
        drive(32'h11, 32'h0, 0, 0, 0, 1, 32'hC3, 0, "R4 R6 off1");
        drive(32'h12, 32'h0, 0, 0, 0, 1, 32'hB2, 0, "R4 R6 off2");
        drive(32'h13, 32'h0, 0, 0, 0, 1, 32'hA1, 0, "R4 R6 off3");
        drive(32'h10, 32'h0, 0, 0, 1, 1, 32'hA1, 0, "R5 off0");
        drive(32'h11, 32'h0, 0, 0, 1, 1, 32'hB2, 0, "R5 off1");
        drive(32'h12, 32'h0, 0, 0, 1, 1, 32'hC3, 0, "R5 off2");
        drive(32'h13, 32'h0, 0, 0, 1, 1, 32'hD4, 0, "R5 off3");
        // byte stores touch one lane each
        drive(32'h11, 32'hFFFFFF5E, 1, 0, 0, 0, 32'h0, 0, "R7");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hA1B25ED4, 0, "R7 little store");
        drive(32'h11, 32'h00000077, 1, 0, 1, 0, 32'h0, 0, "R7");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hA1775ED4, 0, "R7 big store");
        // misaligned word accesses
        drive(32'h12, 32'hDEADBEEF, 1, 1, 0, 1, 32'hA1775ED4, 1, "R8 store");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hA1775ED4, 0, "R8 unchanged");
        drive(32'h13, 32'h0, 0, 1, 1, 1, 32'hA1775ED4, 1, "R8 load");
        // byte accesses at odd offsets never flag
        drive(32'h13, 32'h0, 0, 0, 0, 1, 32'hA1, 0, "R9 load");
        drive(32'h13, 32'h00000042, 1, 0, 1, 1, 32'hD4, 0, "R9 store");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hA1775E42, 0, "R5 R7 big off3 store");
        // aliasing of high address bits
        drive(32'h20, 32'h13579BDF, 1, 1, 0, 0, 32'h0, 0, "R10");
        drive(32'h120, 32'h0, 0, 1, 0, 1, 32'h13579BDF, 0, "R10 alias 0x120");
        drive(32'h80000020, 32'h0, 0, 1, 1, 1, 32'h13579BDF, 0, "R10 alias high");
        // same-clock store and load
        drive(32'h10, 32'hCAFEF00D, 1, 1, 0, 1, 32'hA1775E42, 0, "R11 old data");
        drive(32'h10, 32'h0, 0, 1, 0, 1, 32'hCAFEF00D, 0, "R11 new data");
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule